// File: doc/BRIEF.md
# Shared Product-Term Logic Array

This block is the combinational core of one programmable function block. Forty input signals feed an AND plane that forms up to fifty-six product terms. Each term is an AND of any mix of true and inverted inputs. An OR plane then combines those terms into sixteen sum-of-products outputs, one per macrocell. Any term can feed any number of the sixteen outputs, so a product needed by several outputs is built only once. Every term reaches its outputs through the same two plane levels, whichever outputs use it.

The programming of both planes sits in an internal image register. This register is filled through a one-bit serial port while a load strobe is high. A flag reports when the last bit of a full image has arrived. Until that point both the term vector and the sums read zero. After that, both follow the inputs with no clock involved.

Top module: `pla_shared`

## Requirements
- R1: While `rst` is high and after it, `cfg_done` is 0, and `pt_out` and `sum_out` are all zeros whatever `pla_in` carries.
- R2: `cfg_done` rises at the clock edge that captures bit number CFG_W (5376 by default) of one unbroken `cfg_load` burst. Until then `pt_out` and `sum_out` stay all zeros. After CFG_W-1 bits the flag is still 0.
- R3: Image layout. The first bit shifted is the image MSB. The AND field takes the upper 2*N_IN*N_PT bits and the OR field the lower N_PT*N_OUT bits. Within the AND field, term p input i uses a true-enable at bit 2*(p*N_IN+i)+1 and a complement-enable at bit 2*(p*N_IN+i). Within the OR field, term p reaches output o through bit p*N_OUT+o.
- R4: A product term is 1 only when every enabled true literal sees a 1 and every enabled complement literal sees a 0.
- R5: Enabling both the true and the complement form of one input forces that term to 0.
- R6: A term with no literal enabled is 0, and so is any output fed only by such terms.
- R7: A sum output is the OR of the terms connected to it. An output with no connected term is 0.
- R8: One product term may drive all 16 outputs at the same time.
- R9: The pair X = A&B | C and Y = A&B | !C is built from exactly three terms, with A&B shared by both outputs.
- R10: Each new `cfg_load` burst clears `cfg_done` one edge after it starts, and a cut-short burst leaves the outputs at zero. While `cfg_load` is low, `cfg_din` has no effect.
- R11: Once configured, `pt_out` and `sum_out` follow `pla_in` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration loader |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Serial load strobe; each high cycle shifts in one bit |
| cfg_din | input | 1 | Serial configuration data, image MSB first |
| cfg_done | output | 1 | High once a full image has been received |
| pla_in | input | N_IN (40) | Array input signals |
| pt_out | output | N_PT (56) | Product-term vector |
| sum_out | output | N_OUT (16) | Sum-of-products outputs |

## Verification
The hardest state to reach from the ports is a precise configuration. It takes a full 5376-bit serial image, and a single misplaced bit moves a literal to another term or input. The bench therefore builds the image in its own register using the bit-position rules of R3. It shifts that image MSB first, checks that the flag is still low one bit before the end, and then walks a vector table. A second, cut-short burst and a final reload show that the flag drops and that the outputs return once the image is complete.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Literal pass test: a disabled literal always passes.
  function automatic logic lit_pass(input logic en_true, input logic en_comp, input logic x);
    return (!en_true || x) && (!en_comp || !x);
  endfunction

  function automatic int and_field_w(input int n_in, input int n_pt);
    return 2 * n_in * n_pt;
  endfunction

  function automatic int or_field_w(input int n_pt, input int n_out);
    return n_pt * n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             din,
  output logic [CFG_W-1:0] image,
  output logic             done
);
  localparam int CW = $clog2(CFG_W + 1);

  logic [CW-1:0] cnt;
  logic          load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      image  <= '0;
      cnt    <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load;
      if (load) begin
        image <= {image[CFG_W-2:0], din};
        if (!load_q)
          cnt <= CW'(1);
        else if (cnt != CW'(CFG_W))
          cnt <= cnt + CW'(1);
      end
    end
  end

  assign done = (cnt == CW'(CFG_W));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 40,
  parameter int N_PT = 56
) (
  input  logic [2*N_IN*N_PT-1:0] cfg,
  input  logic [N_IN-1:0]        in_v,
  output logic [N_PT-1:0]        pt
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic [N_IN-1:0] pass_v;
    logic [N_IN-1:0] used_v;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      localparam int B = 2 * (p * N_IN + i);
      assign pass_v[i] = pla_pkg::lit_pass(cfg[B+1], cfg[B], in_v[i]);
      assign used_v[i] = cfg[B+1] | cfg[B];
    end
    assign pt[p] = (|used_v) & (&pass_v);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 56,
  parameter int N_OUT = 16
) (
  input  logic [N_PT*N_OUT-1:0] cfg,
  input  logic [N_PT-1:0]       pt,
  output logic [N_OUT-1:0]      sum
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    logic [N_PT-1:0] col;
    for (genvar p = 0; p < N_PT; p++) begin : g_col
      assign col[p] = cfg[p*N_OUT + o];
    end
    assign sum[o] = |(col & pt);
  end
endmodule

// File: rtl/pla_shared.sv
module pla_shared #(
  parameter int N_IN  = 40,
  parameter int N_PT  = 56,
  parameter int N_OUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_din,
  output logic             cfg_done,
  input  logic [N_IN-1:0]  pla_in,
  output logic [N_PT-1:0]  pt_out,
  output logic [N_OUT-1:0] sum_out
);
  localparam int AND_W = pla_pkg::and_field_w(N_IN, N_PT);
  localparam int OR_W  = pla_pkg::or_field_w(N_PT, N_OUT);
  localparam int CFG_W = AND_W + OR_W;

  logic [CFG_W-1:0] image;
  logic [N_PT-1:0]  pt_raw;
  logic [N_OUT-1:0] sum_raw;

  pla_cfg_loader #(.CFG_W(CFG_W)) u_load (
    .clk(clk), .rst(rst), .load(cfg_load), .din(cfg_din),
    .image(image), .done(cfg_done)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .cfg(image[CFG_W-1:OR_W]), .in_v(pla_in), .pt(pt_raw)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .cfg(image[OR_W-1:0]), .pt(pt_raw), .sum(sum_raw)
  );

  assign pt_out  = cfg_done ? pt_raw  : '0;
  assign sum_out = cfg_done ? sum_raw : '0;
endmodule

// File: rtl/pla_shared_chk.sv
module pla_shared_chk #(
  parameter int N_PT  = 56,
  parameter int N_OUT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             cfg_done,
  input logic [N_PT-1:0]  pt_out,
  input logic [N_OUT-1:0] sum_out
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !cfg_done);

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |-> (sum_out == '0 && pt_out == '0));

  a_r7_sum_needs_term: assert property (@(posedge clk) disable iff (rst)
    (|sum_out) |-> (|pt_out));

  a_r10_burst_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_load) |=> !cfg_done);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(cfg_done));
endmodule

bind pla_shared pla_shared_chk #(.N_PT(N_PT), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_done(cfg_done),
  .pt_out(pt_out), .sum_out(sum_out)
);

// File: tb/pla_shared_tb.sv
module pla_shared_tb;
  localparam int N_IN = 40, N_PT = 56, N_OUT = 16;
  localparam int OR_W = N_PT * N_OUT;
  localparam int CFG_W = 2 * N_IN * N_PT + OR_W;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0, cfg_din = 1'b0;
  logic cfg_done;
  logic [N_IN-1:0]  pla_in = '0;
  logic [N_PT-1:0]  pt_out;
  logic [N_OUT-1:0] sum_out;
  logic [CFG_W-1:0] img = '0;
  int n_cmp = 0, n_bad = 0, cycles = 0;

  pla_shared u_dut (.*);

  always #5 clk = ~clk;

  // {pla_in, expected sum, expected pt[5:0], expected pt[55]}
  localparam logic [62:0] TBL [8] = '{
    {40'h00_0000_0000, 16'h0002, 6'b000100, 1'b0},
    {40'h00_0000_0003, 16'h0003, 6'b000101, 1'b0},
    {40'h00_0000_0004, 16'h0001, 6'b000010, 1'b0},
    {40'h00_0000_0007, 16'h0003, 6'b000011, 1'b0},
    {40'h00_0000_0064, 16'h0001, 6'b000010, 1'b0},
    {40'h80_0000_0404, 16'hFFFF, 6'b100010, 1'b0},
    {40'h80_0000_0C04, 16'h0001, 6'b000010, 1'b0},
    {40'h40_0000_0000, 16'h8002, 6'b000100, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_lit(input int p, input int i, input logic tv, input logic cv);
    img[OR_W + 2*(p*N_IN+i) + 1] = tv;
    img[OR_W + 2*(p*N_IN+i)]     = cv;
  endtask

  task automatic conn(input int p, input int o);
    img[p*N_OUT + o] = 1'b1;
  endtask

  task automatic shift_bits(input int nbits);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      if (k == CFG_W - 1) check("R2 done low one bit early", 64'(cfg_done), 64'd0);
      cfg_load = 1'b1;
      cfg_din  = img[CFG_W-1-k];
    end
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_din  = 1'b0;
  endtask

  task automatic run_table();
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      pla_in = TBL[v][62:23];
      #1; // R11: no clock edge between drive and sample
      check($sformatf("R4/R7/R9 sum v%0d", v), 64'(sum_out), 64'(TBL[v][22:7]));
      check($sformatf("R4/R5/R6 pt v%0d", v), 64'(pt_out[5:0]), 64'(TBL[v][6:1]));
      check($sformatf("R3 pt55 v%0d", v), 64'(pt_out[55]), 64'(TBL[v][0]));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    // R9: X on out0 = A&B | C, Y on out1 = A&B | !C; A,B,C = in0..2
    set_lit(0, 0, 1, 0); set_lit(0, 1, 1, 0);
    set_lit(1, 2, 1, 0); set_lit(2, 2, 0, 1);
    conn(0, 0); conn(1, 0); conn(0, 1); conn(2, 1);
    set_lit(3, 5, 1, 1); set_lit(3, 6, 1, 0); conn(3, 4);   // R5
    conn(4, 2);                                             // R6 empty term
    set_lit(5, 10, 1, 0); set_lit(5, 11, 0, 1); set_lit(5, 39, 1, 0);
    for (int o = 0; o < N_OUT; o++) conn(5, o);             // R8
    set_lit(55, 38, 1, 0); conn(55, 15);                    // R3 far corner

    pla_in = '1;
    repeat (3) @(negedge clk);
    check("R1 done in reset", 64'(cfg_done), 64'd0);
    check("R1 sum in reset", 64'(sum_out), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pt after reset", 64'(pt_out), 64'd0);
    check("R2 sum before load", 64'(sum_out), 64'd0);

    shift_bits(CFG_W);
    check("R2 done after full image", 64'(cfg_done), 64'd1);
    run_table();

    // R10: din toggles with load low, outputs unchanged
    pla_in = 40'h80_0000_0404;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    #1;
    check("R10 idle din ignored sum", 64'(sum_out), 64'h0000_0000_0000_FFFF);
    check("R10 idle done kept", 64'(cfg_done), 64'd1);
    cfg_din = 1'b0;

    // R10: cut-short burst clears done and blanks outputs
    shift_bits(10);
    check("R10 short burst done", 64'(cfg_done), 64'd0);
    check("R10 short burst sum", 64'(sum_out), 64'd0);
    check("R10 short burst pt", 64'(pt_out), 64'd0);

    shift_bits(CFG_W);
    check("R2 done after reload", 64'(cfg_done), 64'd1);
    run_table();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule